// File: doc/BRIEF.md
# Stateful-Cell Full Adder Sequencer

This block adds three single-bit operands by running a fixed program of write and read steps over a bank of five single-bit stateful cells. Every cell behaves like a nonvolatile two-terminal element. A write step gives it a pair of terminal drives (t1, t2), and the cell moves to `prev OR (t1 XOR t2)`. A logic 1 drive always stands for the set-level pulse, so a write can only set a cell and never clear it. The one exception is the dedicated clear step. Cells that a step does not address get a protecting drive and keep their state.

Operands enter through a valid/ready handshake. The block accepts a new triple only while it is idle, so `in_ready` is high exactly in that state. The program then runs for eight clock cycles. Two of its steps are readouts: a cell's stored bit is captured in a per-cell readout latch, and a later write uses that latch as a terminal drive. When the program ends, the sum and carry-out come from two designated cells and are presented with `out_valid`. The consumer can apply back-pressure by holding `out_ready` low. The result then stays valid and stable for as long as it is held, and no new operands are accepted until it has been taken. The contents of the whole cell bank are visible on `cell_q`.

Top module: `fa_seq_ctrl`

## Requirements
- R1: During and straight after reset, `in_ready` is 1, `out_valid` is 0 and all five cells read 0.
- R2: Operands are captured only on a cycle with `in_valid` and `in_ready` both high. `in_ready` is low from the cycle after capture until the result is taken. Values on `in_a`, `in_b`, `in_ci` and `in_valid` while busy have no effect on any cell or on the result.
- R3: Program step 1 (the first cycle after capture) clears all five cells together. Between programs, cells keep whatever the last program left in them.
- R4: In a write step, an addressed cell becomes `prev OR (t1 XOR t2)`, where a drive of 1 is the set level. Cells that are not addressed keep their state.
- R5: After each step, with X = A XOR B, the cells hold these values. Step 2: cell0 = X and cell1 = NOT A. Step 4: cell2 = X XOR Ci, cell1 = NAND(A,B) and cell3 = NOT X. Step 5: cell3 = NAND(X,Ci). Step 7: cell4 = X AND Ci. Step 8: cell4 = (X AND Ci) OR (A AND B). All other cells are unchanged at each step.
- R6: Steps 3 and 6 are readouts. Step 3 samples cell0, and step 6 samples cells 1 and 3. A readout changes no cell. The sampled bits are the t1 drives of the writes at steps 4, 7 and 8.
- R7: `out_valid` rises on the eighth clock edge after the capturing edge. At that point `out_sum` (cell2) = A XOR B XOR Ci and `out_cout` (cell4) is the carry of A + B + Ci.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_sum` and `out_cout` hold. A cycle with both `out_valid` and `out_ready` high returns the block to idle, and `in_ready` is high in the following cycle.
- R9: `cell_q[i]` shows the stored state of cell i at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand triple is offered |
| in_ready | output | 1 | Block is idle and will capture operands |
| in_a | input | 1 | Addend A |
| in_b | input | 1 | Addend B |
| in_ci | input | 1 | Carry-in |
| out_valid | output | 1 | Result is available |
| out_ready | input | 1 | Consumer takes the result |
| out_sum | output | 1 | Sum bit (cell 2) |
| out_cout | output | 1 | Carry-out bit (cell 4) |
| cell_q | output | 5 | Stored state of each cell |

## Verification
The bench compares the full cell bank against a behavioural step model on every cycle. A schedule that addresses the wrong cell or skips protection therefore shows up as a stray bit in the first step where it happens, long before the sum is wrong. Each of the eight operand combinations runs after a previous result that is left in the cells. A missing or partial clear would let that leftover set bits that no write could remove, and the final sum or carry would be wrong. Operands are changed with `in_valid` held high during a run. A design that captured while busy would compute from the wrong triple or restart. Results are also held back under back-pressure: a design that dropped `out_valid` early or took new work before release would break the handshake comparison.

// File: rtl/fa_seq_pkg.sv
package fa_seq_pkg;
  localparam int NCELL      = 5;
  localparam int NSTEP      = 8;
  localparam int STEP_W     = $clog2(NSTEP);
  localparam int CELL_W     = $clog2(NCELL);
  localparam int XOR_CELL   = 0;
  localparam int NA_CELL    = 1;
  localparam int SUM_CELL   = 2;
  localparam int NX_CELL    = 3;
  localparam int CARRY_CELL = 4;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_CLEAR = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } cell_op_e;

  typedef enum logic [2:0] {
    SRC_ZERO = 3'd0,
    SRC_ONE  = 3'd1,
    SRC_A    = 3'd2,
    SRC_B    = 3'd3,
    SRC_CI   = 3'd4,
    SRC_RD   = 3'd5
  } drv_src_e;

  typedef struct packed {
    cell_op_e              op;
    drv_src_e              s1;
    logic [CELL_W-1:0]     i1;
    drv_src_e              s2;
    logic [CELL_W-1:0]     i2;
  } cell_cmd_t;

  localparam cell_cmd_t CMD_HOLD = '{op: OP_HOLD, s1: SRC_ZERO, i1: '0, s2: SRC_ZERO, i2: '0};

  function automatic cell_cmd_t mk_op(cell_op_e op);
    cell_cmd_t c;
    c    = CMD_HOLD;
    c.op = op;
    return c;
  endfunction

  function automatic cell_cmd_t mk_wr(drv_src_e a, int ia, drv_src_e b, int ib);
    cell_cmd_t c;
    c.op = OP_WRITE;
    c.s1 = a;
    c.i1 = CELL_W'(ia);
    c.s2 = b;
    c.i2 = CELL_W'(ib);
    return c;
  endfunction

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/fa_sched_rom.sv
module fa_sched_rom
  import fa_seq_pkg::*;
(
  input  logic                          en_i,
  input  logic [STEP_W-1:0]             step_i,
  output cell_cmd_t [NCELL-1:0]         cmd_o
);
  always_comb begin
    for (int c = 0; c < NCELL; c++) cmd_o[c] = CMD_HOLD;
    if (en_i) begin
      case (int'(step_i))
        0: for (int c = 0; c < NCELL; c++) cmd_o[c] = mk_op(OP_CLEAR);
        1: begin
          cmd_o[XOR_CELL] = mk_wr(SRC_A, 0, SRC_B, 0);
          cmd_o[NA_CELL]  = mk_wr(SRC_ONE, 0, SRC_A, 0);
        end
        2: cmd_o[XOR_CELL] = mk_op(OP_READ);
        3: begin
          cmd_o[SUM_CELL] = mk_wr(SRC_RD, XOR_CELL, SRC_CI, 0);
          cmd_o[NA_CELL]  = mk_wr(SRC_ONE, 0, SRC_B, 0);
          cmd_o[NX_CELL]  = mk_wr(SRC_RD, XOR_CELL, SRC_ONE, 0);
        end
        4: cmd_o[NX_CELL] = mk_wr(SRC_ONE, 0, SRC_CI, 0);
        5: begin
          cmd_o[NA_CELL] = mk_op(OP_READ);
          cmd_o[NX_CELL] = mk_op(OP_READ);
        end
        6: cmd_o[CARRY_CELL] = mk_wr(SRC_RD, NX_CELL, SRC_ONE, 0);
        7: cmd_o[CARRY_CELL] = mk_wr(SRC_RD, NA_CELL, SRC_ONE, 0);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fa_drive_mux.sv
module fa_drive_mux
  import fa_seq_pkg::*;
(
  input  drv_src_e            src_i,
  input  logic [CELL_W-1:0]   idx_i,
  input  logic                a_i,
  input  logic                b_i,
  input  logic                ci_i,
  input  logic [NCELL-1:0]    rd_i,
  output logic                drv_o
);
  always_comb begin
    case (src_i)
      SRC_ONE: drv_o = 1'b1;
      SRC_A:   drv_o = a_i;
      SRC_B:   drv_o = b_i;
      SRC_CI:  drv_o = ci_i;
      SRC_RD:  drv_o = (int'(idx_i) < NCELL) ? rd_i[idx_i] : 1'b0;
      default: drv_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fa_cell.sv
module fa_cell
  import fa_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  cell_op_e  op_i,
  input  logic      t1_i,
  input  logic      t2_i,
  output logic      q_o,
  output logic      rd_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_o  <= 1'b0;
      rd_o <= 1'b0;
    end else begin
      case (op_i)
        OP_CLEAR: q_o  <= 1'b0;
        OP_WRITE: q_o  <= q_o | (t1_i ^ t2_i);
        OP_READ:  rd_o <= q_o;
        default:  ;
      endcase
    end
  end

  a_r4_protect_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_HOLD) |=> $stable(q_o));
  a_r6_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_READ) |=> $stable(q_o));
  a_r4_set_only: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_WRITE && q_o) |=> q_o);
  a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_CLEAR) |=> !q_o);
  a_r6_latch_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i != OP_READ) |=> $stable(rd_o));
endmodule

// File: rtl/fa_seq_ctrl.sv
module fa_seq_ctrl
  import fa_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_a,
  input  logic             in_b,
  input  logic             in_ci,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_sum,
  output logic             out_cout,
  output logic [NCELL-1:0] cell_q
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NSTEP - 1);

  seq_state_e          state_q;
  logic [STEP_W-1:0]   step_q;
  logic                a_q, b_q, ci_q;
  logic [NCELL-1:0]    rd_bits;
  cell_cmd_t [NCELL-1:0] cmd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      a_q     <= 1'b0;
      b_q     <= 1'b0;
      ci_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (in_valid) begin
          a_q     <= in_a;
          b_q     <= in_b;
          ci_q    <= in_ci;
          step_q  <= '0;
          state_q <= ST_RUN;
        end
        ST_RUN: begin
          if (step_q == LAST_STEP) state_q <= ST_DONE;
          else                     step_q  <= step_q + 1'b1;
        end
        ST_DONE: if (out_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_DONE);

  fa_sched_rom u_rom (
    .en_i   (state_q == ST_RUN),
    .step_i (step_q),
    .cmd_o  (cmd)
  );

  for (genvar c = 0; c < NCELL; c++) begin : g_cell
    logic t1, t2;
    fa_drive_mux u_mux1 (
      .src_i (cmd[c].s1), .idx_i (cmd[c].i1),
      .a_i (a_q), .b_i (b_q), .ci_i (ci_q), .rd_i (rd_bits), .drv_o (t1)
    );
    fa_drive_mux u_mux2 (
      .src_i (cmd[c].s2), .idx_i (cmd[c].i2),
      .a_i (a_q), .b_i (b_q), .ci_i (ci_q), .rd_i (rd_bits), .drv_o (t2)
    );
    fa_cell u_cell (
      .clk (clk), .rst_n (rst_n), .op_i (cmd[c].op),
      .t1_i (t1), .t2_i (t2), .q_o (cell_q[c]), .rd_o (rd_bits[c])
    );
  end

  assign out_sum  = cell_q[SUM_CELL];
  assign out_cout = cell_q[CARRY_CELL];

  a_r2_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  a_r8_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum) && $stable(out_cout)));
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (in_ready && !out_valid));
  a_r3_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> ##1 (cell_q == '0));
endmodule

// File: tb/fa_seq_ctrl_tb.sv
module fa_seq_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_a = 1'b0, in_b = 1'b0, in_ci = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid, out_sum, out_cout;
  logic [4:0] cell_q;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int m_st = 0;     // 0 idle, 1 run, 2 done
  int m_k = 0;
  logic ma, mb, mc;
  logic [4:0] m_cells = '0;

  always #2 clk = ~clk;

  fa_seq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_ci(in_ci), .out_valid(out_valid),
    .out_ready(out_ready), .out_sum(out_sum), .out_cout(out_cout), .cell_q(cell_q)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // behavioural model: values per step as stated in R3, R5, R6
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_st = 0; m_k = 0; m_cells = '0;
    end else begin
      case (m_st)
        0: if (in_valid) begin ma = in_a; mb = in_b; mc = in_ci; m_k = 0; m_st = 1; end
        1: begin
          case (m_k)
            0: m_cells = '0;
            1: begin m_cells[0] = ma ^ mb; m_cells[1] = ~ma; end
            3: begin m_cells[2] = ma ^ mb ^ mc; m_cells[1] = ~(ma & mb); m_cells[3] = ~(ma ^ mb); end
            4: m_cells[3] = ~((ma ^ mb) & mc);
            6: m_cells[4] = (ma ^ mb) & mc;
            7: m_cells[4] = ((ma ^ mb) & mc) | (ma & mb);
            default: ;
          endcase
          if (m_k == 7) m_st = 2; else m_k++;
        end
        default: if (out_ready) m_st = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int s;
      chk("R2 in_ready", in_ready, m_st == 0);
      chk("R7 out_valid", out_valid, m_st == 2);
      chk("R5/R9 cell_q", cell_q, m_cells);
      if (m_st == 2) begin
        s = ma + mb + mc;
        chk("R7 sum", out_sum, s & 1);
        chk("R7 cout", out_cout, s >> 1);
      end
    end
  end

  task automatic run_op(input logic a, input logic b, input logic c, input int hold, input bit noisy);
    @(negedge clk);
    in_a = a; in_b = b; in_ci = c; in_valid = 1'b1;
    @(negedge clk);
    while (m_st == 0) @(negedge clk);
    in_valid = noisy;
    while (m_st == 1) begin
      if (noisy) begin in_a = ~in_a; in_b = ~in_b; in_ci = ~in_ci; end  // R2 ignored while busy
      @(negedge clk);
    end
    in_valid = 1'b0;
    for (int h = 0; h < hold; h++) begin
      chk("R8 held valid", out_valid, 1);
      @(negedge clk);
    end
    chk("R7 final sum", out_sum, (a + b + c) & 1);
    chk("R7 final cout", out_cout, (int'(a) + b + c) >> 1);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk("R8 ready after release", in_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in_ready in reset", in_ready, 1);
    chk("R1 out_valid in reset", out_valid, 0);
    chk("R1 cells in reset", cell_q, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cells after reset", cell_q, 0);
    // R3 leftover cells from each run must be cleared by the next
    for (int v = 7; v >= 0; v--) run_op(v[2], v[1], v[0], v % 3, v[0] ^ v[1]);
    repeat (2) @(negedge clk);
    chk("R3 cells retained idle", cell_q, m_cells);
    for (int v = 0; v < 8; v++) run_op(v[0], v[2], v[1], 0, 1'b1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #80000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule